// File: doc/BRIEF.md
# Decimal Character Conversion Unit

This unit converts between two number representations held in a pair of 31-bit sign-magnitude words, called A and X. Each word has a sign in bit 30 and a 30-bit magnitude made of five 6-bit bytes. Byte 1, the most significant, sits in bits 29:24, and byte 5 sits in bits 5:0. The decimal digits 0 to 9 are written as the byte codes 30 to 39.

In to-number mode, the ten bytes of A followed by X are read as a ten-digit decimal number, most significant digit first. The binary value of that number becomes the new magnitude of A. In to-character mode, the magnitude of A is written out as ten digit codes spread across A and X.

Each conversion handles one digit per clock cycle and takes ten cycles in total. Commands enter through a valid/ready handshake. Results come back on plain outputs, marked by a one-cycle done pulse, and stay on those outputs until the next command is accepted.

The command side applies back-pressure: `cmd_ready` is low for the whole time the unit is busy, and any `cmd_valid` seen in that time is ignored. The result side has no back-pressure, because results are held on the outputs rather than streamed.

Top module: `dcc_top`

## Requirements
- R1: When the unit is idle, `cmd_ready` is 1. A command is accepted on a rising clock edge where both `cmd_valid` and `cmd_ready` are 1. While `busy` is 1, `cmd_ready` is 0, and `cmd_valid` and the data inputs have no effect on the result.
- R2: After an accepted command, `busy` is 1 for exactly 10 cycles, starting in the cycle right after the accepting edge. `done` is 1 only in the tenth of those cycles. In the cycle after `done`, both `busy` and `done` are 0 and `cmd_ready` is 1.
- R3: When `cmd_to_char` = 0 (to-number mode), the ten bytes are read as decimal digits, most significant first: A byte 1 to byte 5 (bits 29:24 down to 5:0), then X byte 1 to byte 5. The binary value goes to the magnitude of A (bits 29:0). The magnitude of X is left unchanged.
- R4: In to-number mode, if the decimal value is 2^30 or more, the magnitude of A becomes the value modulo 2^30 and `ovf` is 1. Otherwise `ovf` is 0.
- R5: When `cmd_to_char` = 1 (to-character mode), the magnitude of A is written as ten digit codes, each equal to 30 plus the digit. The most significant digit goes to A bits 29:24 and the least significant to X bits 5:0. `ovf` is 0.
- R6: In both modes, the sign bits (bit 30) of A and X on the outputs equal the sign bits given with the command.
- R7: After reset, `a_word_o`, `x_word_o`, `busy`, `done` and `ovf` are all 0. A result shown with `done` stays unchanged on `a_word_o`, `x_word_o` and `ovf` until the next command is accepted.
- R8: In to-number mode, each input byte counts as its value modulo 10. Non-digit codes are therefore accepted, for example 0 counts as 0, 45 as 5 and 63 as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The unit can take a command |
| cmd_to_char | input | 1 | Mode: 0 = to-number, 1 = to-character |
| a_word_i | input | 31 | Sign-magnitude A word given with the command |
| x_word_i | input | 31 | Sign-magnitude X word given with the command |
| a_word_o | output | 31 | Resulting A word, valid from `done` on |
| x_word_o | output | 31 | Resulting X word, valid from `done` on |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | One-cycle pulse: the result is valid |
| ovf | output | 1 | The to-number result exceeded the magnitude range |

## Verification
A wrong cycle count in the control logic shows up directly: `done` appears in the wrong cycle, or `busy` has the wrong length, within the ten cycles of a single command. A fault in the shared byte register is visible only at `done`. In to-number mode it shows as an X magnitude that did not rotate back to its input value. In to-character mode it shows as digits in the wrong positions. A wrong accumulator or quotient state, or a sticky overflow bit that is cleared too early, shows in the A magnitude or in `ovf` at that same `done` cycle.

The directed cases are placed where such faults separate from correct behaviour: the exact range boundary, an all-nines input, a zero input, and non-digit codes. Random commands, including junk offered while the unit is busy, cover the rest.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  // conversion direction selected per command
  typedef enum logic {
    MODE_TO_NUM  = 1'b0,
    MODE_TO_CHAR = 1'b1
  } conv_mode_e;

  localparam int RADIX = 10;
  // extra accumulator bits so that acc*10+9 never wraps before the overflow test
  localparam int GUARD_W = 4;
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl #(
  parameter int DIGITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  output logic accept,
  output logic step_en,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(DIGITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGITS);

  // number of digits already processed for the current command
  logic [CNT_W-1:0] steps_q;

  assign busy      = (steps_q != '0);
  assign done      = (steps_q == LAST);
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;
  // first digit is handled on the accepting edge, the rest while busy
  assign step_en   = accept | (busy & ~done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q <= '0;
    end else if (accept) begin
      steps_q <= CNT_W'(1);
    end else if (done) begin
      steps_q <= '0;
    end else if (busy) begin
      steps_q <= steps_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dcc_pack_step.sv
module dcc_pack_step
  import dcc_pkg::*;
#(
  parameter int BYTE_W = 6,
  parameter int MAG_W  = 30,
  parameter int SHR_W  = 60
) (
  input  logic [SHR_W-1:0] shreg_i,
  input  logic [MAG_W-1:0] acc_i,
  input  logic             ovf_i,
  output logic [SHR_W-1:0] shreg_o,
  output logic [MAG_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam int WIDE_W = MAG_W + GUARD_W;

  logic [BYTE_W-1:0] head_byte;
  logic [BYTE_W-1:0] digit;
  logic [WIDE_W-1:0] wide;

  assign head_byte = shreg_i[SHR_W-1 -: BYTE_W];
  // any byte code contributes its value modulo ten
  assign digit     = head_byte % BYTE_W'(RADIX);
  assign wide      = WIDE_W'(acc_i) * WIDE_W'(RADIX) + WIDE_W'(digit);
  assign acc_o     = wide[MAG_W-1:0];
  // value grows monotonically, so the first crossing is seen exactly
  assign ovf_o     = ovf_i | (|wide[WIDE_W-1:MAG_W]);
  // rotate: after all digits the byte register holds its original contents
  assign shreg_o   = {shreg_i[SHR_W-BYTE_W-1:0], head_byte};
endmodule

// File: rtl/dcc_unpack_step.sv
module dcc_unpack_step
  import dcc_pkg::*;
#(
  parameter int BYTE_W     = 6,
  parameter int MAG_W      = 30,
  parameter int SHR_W      = 60,
  parameter int DIGIT_BASE = 30
) (
  input  logic [SHR_W-1:0] shreg_i,
  input  logic [MAG_W-1:0] acc_i,
  output logic [SHR_W-1:0] shreg_o,
  output logic [MAG_W-1:0] acc_o
);
  logic [MAG_W-1:0]  quot;
  logic [MAG_W-1:0]  rem_w;
  logic [BYTE_W-1:0] code;

  assign quot    = acc_i / MAG_W'(RADIX);
  assign rem_w   = acc_i % MAG_W'(RADIX);
  assign code    = BYTE_W'(DIGIT_BASE) + BYTE_W'(rem_w);
  // least significant digit enters first and drifts down to the bottom byte
  assign shreg_o = {code, shreg_i[SHR_W-1:BYTE_W]};
  assign acc_o   = quot;
endmodule

// File: rtl/dcc_top.sv
module dcc_top
  import dcc_pkg::*;
#(
  parameter int BYTE_W     = 6,
  parameter int BYTES      = 5,
  parameter int DIGIT_BASE = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_to_char,
  input  logic [BYTE_W*BYTES:0]    a_word_i,
  input  logic [BYTE_W*BYTES:0]    x_word_i,
  output logic [BYTE_W*BYTES:0]    a_word_o,
  output logic [BYTE_W*BYTES:0]    x_word_o,
  output logic                     busy,
  output logic                     done,
  output logic                     ovf
);
  localparam int MAG_W  = BYTE_W * BYTES;
  localparam int SHR_W  = 2 * MAG_W;
  localparam int DIGITS = 2 * BYTES;

  logic accept, step_en;

  conv_mode_e       mode_q, src_mode;
  logic             sign_a_q, sign_x_q;
  logic [SHR_W-1:0] shreg_q, src_shreg, pk_shreg, up_shreg;
  logic [MAG_W-1:0] acc_q, src_acc, pk_acc, up_acc;
  logic             ovf_q, src_ovf, pk_ovf;

  dcc_ctrl #(.DIGITS(DIGITS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .accept   (accept),
    .step_en  (step_en),
    .busy     (busy),
    .done     (done)
  );

  // on the accepting edge the first step works straight from the inputs
  always_comb begin
    if (accept) begin
      src_mode  = conv_mode_e'(cmd_to_char);
      src_shreg = {a_word_i[MAG_W-1:0], x_word_i[MAG_W-1:0]};
      src_acc   = cmd_to_char ? a_word_i[MAG_W-1:0] : '0;
      src_ovf   = 1'b0;
    end else begin
      src_mode  = mode_q;
      src_shreg = shreg_q;
      src_acc   = acc_q;
      src_ovf   = ovf_q;
    end
  end

  dcc_pack_step #(.BYTE_W(BYTE_W), .MAG_W(MAG_W), .SHR_W(SHR_W)) u_pack (
    .shreg_i(src_shreg),
    .acc_i  (src_acc),
    .ovf_i  (src_ovf),
    .shreg_o(pk_shreg),
    .acc_o  (pk_acc),
    .ovf_o  (pk_ovf)
  );

  dcc_unpack_step #(
    .BYTE_W(BYTE_W), .MAG_W(MAG_W), .SHR_W(SHR_W), .DIGIT_BASE(DIGIT_BASE)
  ) u_unpack (
    .shreg_i(src_shreg),
    .acc_i  (src_acc),
    .shreg_o(up_shreg),
    .acc_o  (up_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_TO_NUM;
      sign_a_q <= 1'b0;
      sign_x_q <= 1'b0;
      shreg_q  <= '0;
      acc_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (accept) begin
        mode_q   <= src_mode;
        sign_a_q <= a_word_i[MAG_W];
        sign_x_q <= x_word_i[MAG_W];
      end
      if (step_en) begin
        if (src_mode == MODE_TO_CHAR) begin
          shreg_q <= up_shreg;
          acc_q   <= up_acc;
          ovf_q   <= 1'b0;
        end else begin
          shreg_q <= pk_shreg;
          acc_q   <= pk_acc;
          ovf_q   <= pk_ovf;
        end
      end
    end
  end

  assign a_word_o = (mode_q == MODE_TO_CHAR) ?
                    {sign_a_q, shreg_q[SHR_W-1 -: MAG_W]} :
                    {sign_a_q, acc_q};
  assign x_word_o = {sign_x_q, shreg_q[MAG_W-1:0]};
  assign ovf      = ovf_q;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int BYTE_W     = 6,
  parameter int BYTES      = 5,
  parameter int DIGIT_BASE = 30
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic                  cmd_to_char,
  input logic                  a_sign_i,
  input logic [BYTE_W*BYTES:0] x_word_i,
  input logic [BYTE_W*BYTES:0] a_word_o,
  input logic [BYTE_W*BYTES:0] x_word_o,
  input logic                  busy,
  input logic                  done,
  input logic                  ovf
);
  localparam int MAG_W  = BYTE_W * BYTES;
  localparam int DIGITS = 2 * BYTES;
  localparam int CNT_W  = $clog2(DIGITS + 1);

  logic             acc_ev;
  logic [CNT_W-1:0] cyc_q;
  logic             mode_c, sa_c, sx_c;
  logic [MAG_W-1:0] xm_c;

  assign acc_ev = cmd_valid & cmd_ready;

  // independent count of cycles since the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      mode_c <= 1'b0;
      sa_c   <= 1'b0;
      sx_c   <= 1'b0;
      xm_c   <= '0;
    end else begin
      if (acc_ev) begin
        cyc_q  <= CNT_W'(1);
        mode_c <= cmd_to_char;
        sa_c   <= a_sign_i;
        sx_c   <= x_word_i[MAG_W];
        xm_c   <= x_word_i[MAG_W-1:0];
      end else if (cyc_q == CNT_W'(DIGITS)) begin
        cyc_q <= '0;
      end else if (cyc_q != '0) begin
        cyc_q <= cyc_q + CNT_W'(1);
      end
    end
  end

  function automatic logic all_codes(input logic [2*MAG_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[i*BYTE_W +: BYTE_W] < BYTE_W'(DIGIT_BASE) ||
          v[i*BYTE_W +: BYTE_W] > BYTE_W'(DIGIT_BASE + 9))
        ok = 1'b0;
    end
    return ok;
  endfunction

  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |=> busy && !done);

  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (cyc_q != '0));

  a_r2_done_slot: assert property (@(posedge clk) disable iff (!rst_n)
    done == (cyc_q == CNT_W'(DIGITS)));

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r3_x_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_c) |-> x_word_o[MAG_W-1:0] == xm_c);

  a_r5_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_c) |-> all_codes({a_word_o[MAG_W-1:0], x_word_o[MAG_W-1:0]}));

  a_r5_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_c) |-> !ovf);

  a_r6_signs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (a_word_o[MAG_W] == sa_c) && (x_word_o[MAG_W] == sx_c));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done || (!busy && !acc_ev)) |=>
      $stable(a_word_o) && $stable(x_word_o) && $stable(ovf));
endmodule

bind dcc_top dcc_checker #(
  .BYTE_W(BYTE_W), .BYTES(BYTES), .DIGIT_BASE(DIGIT_BASE)
) u_dcc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_to_char(cmd_to_char),
  .a_sign_i   (a_word_i[BYTE_W*BYTES]),
  .x_word_i   (x_word_i),
  .a_word_o   (a_word_o),
  .x_word_o   (x_word_o),
  .busy       (busy),
  .done       (done),
  .ovf        (ovf)
);

// File: tb/test_dcc_top.sv
`timescale 1ns/1ps
module test_dcc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_to_char = 1'b0;
  logic [30:0] a_word_i = '0;
  logic [30:0] x_word_i = '0;
  logic [30:0] a_word_o, x_word_o;
  logic        busy, done, ovf;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dcc_top i_dcc_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_to_char(cmd_to_char), .a_word_i(a_word_i), .x_word_i(x_word_i),
    .a_word_o(a_word_o), .x_word_o(x_word_o), .busy(busy), .done(done), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected to-number result: {ovf, magnitude}
  function automatic logic [30:0] model_num(input logic [30:0] a, input logic [30:0] x);
    logic [63:0] v;
    logic [59:0] bytes;
    v = 0;
    bytes = {a[29:0], x[29:0]};
    for (int i = 0; i < 10; i++) v = v * 10 + 64'(bytes[59-6*i -: 6] % 6'd10);
    return {(v >= 64'd1073741824), v[29:0]};
  endfunction

  function automatic logic [59:0] model_char(input logic [29:0] m);
    logic [59:0] r;
    logic [29:0] v;
    v = m;
    r = '0;
    for (int i = 0; i < 10; i++) begin
      r[6*i +: 6] = 6'(30 + (v % 10));
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [29:0] digits5(input int d4, d3, d2, d1, d0);
    return {6'(30+d4), 6'(30+d3), 6'(30+d2), 6'(30+d1), 6'(30+d0)};
  endfunction

  task automatic run_cmd(input logic to_char, input logic [30:0] a,
                         input logic [30:0] x, input bit junk);
    logic [30:0] ea, ex;
    logic        eo;
    logic [30:0] nres;
    logic [59:0] cres;
    if (to_char) begin
      cres = model_char(a[29:0]);
      ea = {a[30], cres[59:30]};
      ex = {x[30], cres[29:0]};
      eo = 1'b0;
    end else begin
      nres = model_num(a, x);
      ea = {a[30], nres[29:0]};
      ex = x;
      eo = nres[30];
    end
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", 64'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_to_char = to_char; a_word_i = a; x_word_i = x;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (junk && k >= 2 && k <= 7) begin  // R1: offers while busy are ignored
        cmd_valid = 1'b1; cmd_to_char = ~to_char;
        a_word_i = 31'($urandom); x_word_i = 31'($urandom);
      end else begin
        cmd_valid = 1'b0;
      end
      chk(busy == 1'b1 && done == (k == 10) && cmd_ready == 1'b0,
          "R2 busy/done timing", {62'(0), busy, done}, {62'(0), 1'b1, 1'(k == 10)});
    end
    chk(a_word_o[29:0] == ea[29:0], to_char ? "R5 A digits" : "R3 A value",
        64'(a_word_o[29:0]), 64'(ea[29:0]));
    chk(x_word_o[29:0] == ex[29:0], to_char ? "R5 X digits" : "R3 X kept",
        64'(x_word_o[29:0]), 64'(ex[29:0]));
    chk(ovf == eo, to_char ? "R5 no overflow" : "R4 overflow flag", 64'(ovf), 64'(eo));
    chk(a_word_o[30] == ea[30] && x_word_o[30] == ex[30], "R6 signs",
        {62'(0), a_word_o[30], x_word_o[30]}, {62'(0), ea[30], ex[30]});
    @(negedge clk);
    chk(!busy && !done && cmd_ready, "R2 idle after done",
        {61'(0), busy, done, cmd_ready}, 64'd1);
    chk(a_word_o == ea && x_word_o == ex && ovf == eo, "R7 result held",
        64'(a_word_o), 64'(ea));
  endtask

  function automatic logic [5:0] rnd_byte();
    if ($urandom % 5 == 0) return 6'($urandom % 64);
    return 6'(30 + $urandom % 10);
  endfunction

  function automatic logic [30:0] rnd_word();
    logic [30:0] w;
    w[30] = 1'($urandom);
    for (int i = 0; i < 5; i++) w[6*i +: 6] = rnd_byte();
    return w;
  endfunction

  initial begin
    logic [30:0] ex_a, ex_x;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(a_word_o == 0 && x_word_o == 0 && !busy && !done && !ovf && cmd_ready,
        "R7 reset state", 64'(a_word_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(a_word_o == 0 && !busy && !done, "R7 idle after reset", 64'(a_word_o), 0);

    // R3 worked example: 0012315904
    ex_a = {1'b0, digits5(0, 0, 1, 2, 3)};
    ex_x = {1'b0, digits5(1, 5, 9, 0, 4)};
    run_cmd(1'b0, ex_a, ex_x, 1'b0);
    chk(a_word_o == 31'd12315904, "R3 example value", 64'(a_word_o), 64'd12315904);
    // R4 exact limit 1073741823: no overflow
    run_cmd(1'b0, {1'b1, digits5(1, 0, 7, 3, 7)}, {1'b0, digits5(4, 1, 8, 2, 3)}, 1'b0);
    chk(a_word_o[29:0] == 30'h3FFFFFFF && !ovf, "R4 limit", 64'(a_word_o[29:0]), 64'h3FFFFFFF);
    // R4 one above: wraps to zero
    run_cmd(1'b0, {1'b0, digits5(1, 0, 7, 3, 7)}, {1'b1, digits5(4, 1, 8, 2, 4)}, 1'b0);
    chk(a_word_o[29:0] == 0 && ovf, "R4 just over", 64'(a_word_o[29:0]), 0);
    // R4 all nines
    run_cmd(1'b0, {1'b0, digits5(9, 9, 9, 9, 9)}, {1'b0, digits5(9, 9, 9, 9, 9)}, 1'b1);
    chk(a_word_o[29:0] == 30'd336323583, "R4 all nines", 64'(a_word_o[29:0]), 64'd336323583);
    // R8 non-digit codes: 0->0, 45->5, 63->3, 10->0, 57->7
    run_cmd(1'b0, {1'b0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0}, {1'b0, 6'd0, 6'd45, 6'd63, 6'd10, 6'd57}, 1'b0);
    chk(a_word_o[29:0] == 30'd5307, "R8 non-digit codes", 64'(a_word_o[29:0]), 64'd5307);
    // R5 zero and maximum magnitude
    run_cmd(1'b1, {1'b1, 30'd0}, {1'b1, 30'h155}, 1'b0);
    chk(x_word_o[29:0] == digits5(0, 0, 0, 0, 0), "R5 zero", 64'(x_word_o[29:0]), 0);
    run_cmd(1'b1, {1'b0, 30'h3FFFFFFF}, {1'b0, 30'd0}, 1'b1);
    chk(a_word_o[29:0] == digits5(1, 0, 7, 3, 7), "R5 max high half",
        64'(a_word_o[29:0]), 64'(digits5(1, 0, 7, 3, 7)));
    // R5 example inverse
    run_cmd(1'b1, {1'b0, 30'd12315904}, {1'b0, 30'd0}, 1'b0);
    chk(x_word_o[29:0] == digits5(1, 5, 9, 0, 4), "R5 example inverse",
        64'(x_word_o[29:0]), 64'(digits5(1, 5, 9, 0, 4)));

    for (int n = 0; n < 60; n++) begin
      logic m;
      logic [30:0] ra, rx;
      m = 1'($urandom);
      ra = rnd_word();
      rx = rnd_word();
      if (m) ra[29:0] = 30'($urandom);
      run_cmd(m, ra, rx, 1'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule